// File: doc/BRIEF.md
# Pointer-Addressed Register File

This block is the data register file of a small 8-bit accumulator processor. Every location is reached with a 5-bit address. One address, 00h, holds no storage. Any access to it is steered to the location named by a 5-bit pointer register, which sits at 04h. This lets software walk memory with a pointer, for example to clear the general purpose RAM in a loop.

There is one combinational read port and one write port that commits on the clock edge. The ALU's condition flags are part of a status register at 03h. A write to that register cannot overwrite those flags while the same instruction updates them. The two bits that report time-out and power-down come from inputs. Instructions cannot write them.

Peripheral registers are not part of the block. When an access lands on a peripheral address, the block asserts an external read or write strobe and places the resolved address on that port. The peripheral addresses are 01h, 02h and 05h to 08h. Locations 09h to 0Fh are empty.

Top module: `ptrfile`

## Requirements
- R1: General purpose RAM occupies 10h to 1Fh. A write with `wr_en_i` high stores `wr_data_i` at the clock edge. A read returns the stored byte combinationally from `rd_addr_i`.
- R2: The pointer register at 04h keeps `wr_data_i[4:0]` when written. It reads back with bits 7:5 as zero and resets to 00h.
- R3: An access to address 00h is redirected to the location held in the pointer, for both reads and writes. A pointer written at a clock edge steers every later access.
- R4: A read of 00h while the pointer holds 0 returns 00h.
- R5: A write to 00h while the pointer holds 0 has no effect. RAM, pointer and status keep their values, and no external write strobe is raised.
- R6: Locations 09h to 0Fh read as 00h and ignore writes, whether reached directly or through the pointer.
- R7: A read that resolves to a peripheral address raises `ext_rd_o`, drives the resolved address on `ext_rd_addr_o` and returns `ext_rd_data_i`. A write that resolves to a peripheral address raises `ext_wr_o` in the same cycle, with the resolved address and the data, and changes nothing inside the block. The peripheral addresses are 01h, 02h, 05h, 06h, 07h and 08h.
- R8: Status at 03h has this layout: bits 7:5 are a writable field that resets to 0, bit 4 shows `tpd_i[1]` (time-out), bit 3 shows `tpd_i[0]` (power-down), and bits 2:0 are Z, DC and C. Writes never change bits 4:3.
- R9: While `flags_we_i` is high, status bits 2:0 take `flags_i` (Z, DC, C in bit order 2, 1, 0) at the edge, even if the same cycle writes status. Bits 7:5 of such a write still take the written data.
- R10: A status write with `flags_we_i` low loads bits 2:0 from `wr_data_i[2:0]`.
- R11: A write through 00h that resolves to status or to the pointer follows the same rules as a direct write to that location. Incrementing the pointer from 1Fh wraps it to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 8 | Write data |
| flags_we_i | input | 1 | Executing instruction updates Z, DC, C |
| flags_i | input | 3 | New Z, DC, C from the ALU |
| tpd_i | input | 2 | Time-out (bit 1) and power-down (bit 0) status |
| ext_rd_o | output | 1 | Read resolves to a peripheral register |
| ext_rd_addr_o | output | 5 | Resolved read address |
| ext_rd_data_i | input | 8 | Peripheral read data |
| ext_wr_o | output | 1 | Write resolves to a peripheral register |
| ext_wr_addr_o | output | 5 | Resolved write address |
| ext_wr_data_o | output | 8 | Peripheral write data |

## Verification
The bench builds the block with its default parameters: 5-bit addresses, 8-bit data, sixteen RAM bytes based at 10h, and peripherals at 01h, 02h and 05h to 08h. With these values, the empty range 09h to 0Fh can be reached through the pointer. A pointer-increment clear loop ends when the pointer's bit 4 carries out. The status register is driven through both direct and redirected writes, with the flag update both present and absent.

// File: rtl/ptrfile_pkg.sv
package ptrfile_pkg;
  typedef enum logic [2:0] {
    LOC_NULL, LOC_GPR, LOC_PTR, LOC_STAT, LOC_EXT, LOC_UNIMP
  } loc_e;

  localparam int unsigned FLAG_W    = 3;
  localparam int unsigned ST_PD     = 3;
  localparam int unsigned ST_TO     = 4;
  localparam int unsigned ST_USR_LO = 5;
endpackage

// File: rtl/ptrfile_decode.sv
module ptrfile_decode
  import ptrfile_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned IND_ADDR  = 0,
  parameter int unsigned STAT_ADDR = 3,
  parameter int unsigned PTR_ADDR  = 4,
  parameter int unsigned GPR_BASE  = 16,
  parameter int unsigned GPR_DEPTH = 16,
  parameter logic [(1<<AW)-1:0] EXT_MASK = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] eff_o,
  output loc_e          loc_o
);
  always_comb begin
    eff_o = (addr_i == AW'(IND_ADDR)) ? ptr_i : addr_i;
    if (eff_o == AW'(IND_ADDR))                         loc_o = LOC_NULL;
    else if (eff_o == AW'(PTR_ADDR))                    loc_o = LOC_PTR;
    else if (eff_o == AW'(STAT_ADDR))                   loc_o = LOC_STAT;
    else if (32'(eff_o) >= GPR_BASE &&
             32'(eff_o) <  GPR_BASE + GPR_DEPTH)        loc_o = LOC_GPR;
    else if (EXT_MASK[eff_o])                           loc_o = LOC_EXT;
    else                                                loc_o = LOC_UNIMP;
  end
endmodule

// File: rtl/ptrfile_gpr.sv
module ptrfile_gpr #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] widx_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] ridx_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [DEPTH-1:0][DW-1:0] words;

  // No reset on storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (we_i && widx_i == IW'(g)) word_q <= wdata_i;
    end
    assign words[g] = word_q;
  end

  assign rdata_o = words[ridx_i];

  a_r1_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> words[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/ptrfile_status.sv
module ptrfile_status
  import ptrfile_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              flags_we_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [1:0]        tpd_i,
  output logic [DW-1:0]     status_o
);
  localparam int unsigned UW = DW - ST_USR_LO;

  logic [UW-1:0]     usr_q;
  logic [FLAG_W-1:0] flag_q;
  logic              unused_ro;

  assign unused_ro = ^wdata_i[ST_TO:ST_PD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_i) usr_q <= wdata_i[DW-1:ST_USR_LO];
      // ALU flag update wins over the data write
      if (flags_we_i)  flag_q <= flags_i;
      else if (wr_i)   flag_q <= wdata_i[FLAG_W-1:0];
    end
  end

  assign status_o = {usr_q, tpd_i, flag_q};

  a_r9_flags_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_i |=> status_o[FLAG_W-1:0] == $past(flags_i));
  a_r10_direct_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flags_we_i) |=> status_o[FLAG_W-1:0] == $past(wdata_i[FLAG_W-1:0]));
  a_r8_usr_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> status_o[DW-1:ST_USR_LO] == $past(wdata_i[DW-1:ST_USR_LO]));
  a_r8_ro_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_TO:ST_PD] == tpd_i);
endmodule

// File: rtl/ptrfile.sv
module ptrfile
  import ptrfile_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned DW        = 8,
  parameter int unsigned IND_ADDR  = 0,
  parameter int unsigned STAT_ADDR = 3,
  parameter int unsigned PTR_ADDR  = 4,
  parameter int unsigned GPR_BASE  = 16,
  parameter int unsigned GPR_DEPTH = 16,
  parameter logic [(1<<AW)-1:0] EXT_MASK = 32'h0000_01E6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              flags_we_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [1:0]        tpd_i,
  output logic              ext_rd_o,
  output logic [AW-1:0]     ext_rd_addr_o,
  input  logic [DW-1:0]     ext_rd_data_i,
  output logic              ext_wr_o,
  output logic [AW-1:0]     ext_wr_addr_o,
  output logic [DW-1:0]     ext_wr_data_o
);
  localparam int unsigned GIW = $clog2(GPR_DEPTH);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] rd_eff, wr_eff;
  loc_e          rd_loc, wr_loc;
  logic [DW-1:0] gpr_rdata, status;
  logic          gpr_we, stat_we;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [AW-1:0] addr, eff;
    loc_e          loc;
    if (p == 0) begin : g_rd
      assign addr = rd_addr_i;
      assign rd_eff = eff;
      assign rd_loc = loc;
    end else begin : g_wr
      assign addr = wr_addr_i;
      assign wr_eff = eff;
      assign wr_loc = loc;
    end
    ptrfile_decode #(
      .AW(AW), .IND_ADDR(IND_ADDR), .STAT_ADDR(STAT_ADDR), .PTR_ADDR(PTR_ADDR),
      .GPR_BASE(GPR_BASE), .GPR_DEPTH(GPR_DEPTH), .EXT_MASK(EXT_MASK)
    ) u_dec (
      .addr_i(addr), .ptr_i(ptr_q), .eff_o(eff), .loc_o(loc)
    );
  end

  assign gpr_we  = wr_en_i && wr_loc == LOC_GPR;
  assign stat_we = wr_en_i && wr_loc == LOC_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ptr_q <= '0;
    else if (wr_en_i && wr_loc == LOC_PTR) ptr_q <= wr_data_i[AW-1:0];
  end

  ptrfile_gpr #(.DW(DW), .DEPTH(GPR_DEPTH)) u_gpr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (gpr_we),
    .widx_i  (wr_eff[GIW-1:0] - GIW'(GPR_BASE)),
    .wdata_i (wr_data_i),
    .ridx_i  (rd_eff[GIW-1:0] - GIW'(GPR_BASE)),
    .rdata_o (gpr_rdata)
  );

  ptrfile_status #(.DW(DW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (stat_we),
    .wdata_i    (wr_data_i),
    .flags_we_i (flags_we_i),
    .flags_i    (flags_i),
    .tpd_i      (tpd_i),
    .status_o   (status)
  );

  always_comb begin
    unique case (rd_loc)
      LOC_GPR:  rd_data_o = gpr_rdata;
      LOC_PTR:  rd_data_o = DW'(ptr_q);
      LOC_STAT: rd_data_o = status;
      LOC_EXT:  rd_data_o = ext_rd_data_i;
      default:  rd_data_o = '0;
    endcase
  end

  assign ext_rd_o      = rd_loc == LOC_EXT;
  assign ext_rd_addr_o = rd_eff;
  assign ext_wr_o      = wr_en_i && wr_loc == LOC_EXT;
  assign ext_wr_addr_o = wr_eff;
  assign ext_wr_data_o = wr_data_i;

  a_r4_null_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(IND_ADDR) && ptr_q == '0) |-> rd_data_o == '0);
  a_r5_null_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(IND_ADDR) && ptr_q == '0)
      |-> (!gpr_we && !stat_we && !ext_wr_o));
  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_loc == LOC_PTR) |=> ptr_q == $past(wr_data_i[AW-1:0]));
  a_r6_unimp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_loc == LOC_UNIMP |-> rd_data_o == '0);
  a_r7_ext_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_o |-> rd_data_o == ext_rd_data_i);
endmodule

// File: tb/tb_ptrfile.sv
module tb_ptrfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] wr_data = '0, ext_rd_data = 8'hA5;
  logic       wr_en = 1'b0, flags_we = 1'b0;
  logic [2:0] flags = '0;
  logic [1:0] tpd = 2'b11;
  logic [7:0] rd_data, ext_wr_data;
  logic       ext_rd, ext_wr;
  logic [4:0] ext_rd_addr, ext_wr_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptrfile dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .flags_we_i(flags_we), .flags_i(flags), .tpd_i(tpd),
    .ext_rd_o(ext_rd), .ext_rd_addr_o(ext_rd_addr), .ext_rd_data_i(ext_rd_data),
    .ext_wr_o(ext_wr), .ext_wr_addr_o(ext_wr_addr), .ext_wr_data_o(ext_wr_data)
  );

  // {we, wr_addr, wr_data, rd_addr, expected read before the edge}
  localparam int NV = 19;
  localparam logic [26:0] VECS [NV] = '{
    {1'b0, 5'h04, 8'h00, 5'h04, 8'h00},
    {1'b0, 5'h00, 8'h00, 5'h00, 8'h00},
    {1'b1, 5'h10, 8'h11, 5'h03, 8'h18},
    {1'b1, 5'h1F, 8'h22, 5'h10, 8'h11},
    {1'b1, 5'h04, 8'hE9, 5'h1F, 8'h22},
    {1'b1, 5'h0A, 8'h77, 5'h04, 8'h09},
    {1'b1, 5'h00, 8'h55, 5'h0A, 8'h00},
    {1'b0, 5'h00, 8'h00, 5'h00, 8'h00},
    {1'b1, 5'h04, 8'h10, 5'h01, 8'hA5},
    {1'b1, 5'h00, 8'h66, 5'h00, 8'h11},
    {1'b0, 5'h00, 8'h00, 5'h10, 8'h66},
    {1'b1, 5'h04, 8'h03, 5'h00, 8'h66},
    {1'b1, 5'h00, 8'hFF, 5'h00, 8'h18},
    {1'b0, 5'h00, 8'h00, 5'h03, 8'hFF},
    {1'b1, 5'h04, 8'h00, 5'h00, 8'hFF},
    {1'b1, 5'h00, 8'h5A, 5'h00, 8'h00},
    {1'b0, 5'h00, 8'h00, 5'h03, 8'hFF},
    {1'b0, 5'h00, 8'h00, 5'h04, 8'h00},
    {1'b0, 5'h00, 8'h00, 5'h10, 8'h66}
  };
  string vtag [NV];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive at negedge, commit at posedge, return at next negedge
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic fwe, input logic [2:0] f);
    wr_en = 1'b1; wr_addr = a; wr_data = d; flags_we = fwe; flags = f;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; flags_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    vtag = '{"R2 reset", "R4", "R8", "R1", "R1", "R2", "R6", "R6 R3", "R7",
             "R3", "R3", "R3", "R11", "R11", "R11", "R4", "R5", "R5", "R5"};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i][26]; wr_addr = VECS[i][25:21]; wr_data = VECS[i][20:13];
      rd_addr = VECS[i][12:8];
      #1;
      chk(vtag[i], rd_data, VECS[i][7:0]);
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
    end

    // R10: direct status write without flag update
    wr(5'h03, 8'h05, 1'b0, 3'b000);
    rd(5'h03, v); chk("R10", v, 8'h1D);
    wr(5'h03, 8'hFF, 1'b0, 3'b000);
    rd(5'h03, v); chk("R10", v, 8'hFF);
    // R9: flag-affecting clear of status: 000uu1uu
    wr(5'h03, 8'h00, 1'b1, 3'b111);
    rd(5'h03, v); chk("R9", v, 8'h1F);
    wr_en = 1'b0; flags_we = 1'b1; flags = 3'b010;
    @(posedge clk); @(negedge clk); flags_we = 1'b0;
    rd(5'h03, v); chk("R9", v, 8'h1A);
    // R8: read-only time-out / power-down bits
    tpd = 2'b01;
    rd(5'h03, v); chk("R8", v, 8'h0A);
    wr(5'h03, 8'hFF, 1'b0, 3'b000);
    rd(5'h03, v); chk("R8", v, 8'hEF);

    // R7: peripheral strobes, direct and redirected
    wr_en = 1'b1; wr_addr = 5'h06; wr_data = 8'h3C; #1;
    chk("R7 ext_wr", {7'b0, ext_wr}, 8'h01);
    chk("R7 ext_wr_addr", {3'b0, ext_wr_addr}, 8'h06);
    chk("R7 ext_wr_data", ext_wr_data, 8'h3C);
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(5'h06, v); chk("R7 read", v, 8'hA5);
    chk("R7 ext_rd", {7'b0, ext_rd}, 8'h01);
    wr(5'h04, 8'h07, 1'b0, 3'b000);
    wr_en = 1'b1; wr_addr = 5'h00; wr_data = 8'hC3; rd_addr = 5'h00; #1;
    chk("R7 R3 ext_wr_addr", {3'b0, ext_wr_addr}, 8'h07);
    chk("R7 R3 ext_rd_addr", {3'b0, ext_rd_addr}, 8'h07);
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    // R5: null write raises no strobe
    wr(5'h04, 8'h00, 1'b0, 3'b000);
    wr_en = 1'b1; wr_addr = 5'h00; wr_data = 8'h11; #1;
    chk("R5 ext_wr", {7'b0, ext_wr}, 8'h00);
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(5'h03, v); chk("R5 status", v, 8'hEF);

    // R11 R1: pointer-walk clear of RAM, ends on bit-4 carry
    wr(5'h04, 8'h10, 1'b0, 3'b000);
    for (int k = 0; k < 16; k++) begin
      wr(5'h00, 8'h00, 1'b0, 3'b000);
      wr(5'h04, 8'(16 + k + 1), 1'b0, 3'b000);
    end
    rd(5'h04, v); chk("R11 wrap", v, 8'h00);
    for (int k = 16; k < 32; k++) begin
      rd(5'(k), v); chk("R1 cleared", v, 8'h00);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule